// File: doc/BRIEF.md
# Cascaded-Order Priority Interrupt Controller

This block collects sixteen interrupt request lines and passes one of them at a time to a processor. A rising edge on a line records a pending request for it. The most urgent pending line that is not masked is forwarded on the interrupt output, but only when it outranks every line the processor is still servicing. The processor takes the request with a one-cycle acknowledge strobe, reads the 4-bit line number in the same cycle, and later retires the work with an end-of-interrupt strobe.

Urgency follows a fixed cascaded order rather than the line index. Lines 0 to 2 come first, then lines 8 to 15, then lines 3 to 7. This is the order a second eight-line group would have if it were chained in at line 2. Each line holds a pending bit and an in-service bit. Repeated edges on a line that is already pending are merged into one request. A more urgent request can nest inside a less urgent one that is still in service. Software sets a per-line mask through a write strobe.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, every pending and in-service bit is cleared and every mask bit is set. After reset, `irq_out` is low.
- R2: A 0-to-1 transition on `req_in[i]` sets the pending bit of line i. `irq_out` reflects it 3 clock edges after the input rises. A level held high produces no further requests.
- R3: A write with `mask_we` high loads `mask_wdata`, where bit i = 1 masks line i. A masked line keeps its pending bit but is never forwarded. Unmasking it later raises `irq_out` on the edge that loads the mask.
- R4: Urgency from highest to lowest is 0, 1, 2, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7. When several lines are pending together, they are delivered one per acknowledge in that order.
- R5: While `irq_out` is high, `vec_out` carries the binary number of the forwarded line. An `ack` pulse in that cycle clears that line's pending bit and sets its in-service bit at the next edge.
- R6: A pending unmasked line that outranks every in-service line raises `irq_out`, so it nests inside a lower-ranked interrupt that is still in service.
- R7: A pending line that ranks at or below some in-service line keeps `irq_out` low until end-of-interrupt strobes have cleared every in-service line that ranks above it.
- R8: Any number of edges on one line while it is pending produce exactly one delivery.
- R9: An `eoi` pulse clears the in-service bit of the most urgent in-service line under the order of R4. With no line in service, it has no effect.
- R10: An `ack` pulse while `irq_out` is low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_in | input | 16 | Asynchronous interrupt request lines |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 16 | New mask value, 1 = line blocked |
| ack | input | 1 | Processor acknowledge strobe |
| eoi | input | 1 | Non-specific end-of-interrupt strobe |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 4 | Number of the line being forwarded |

## Verification
A request becomes visible on `irq_out` 3 edges after its input rises: two edges in the synchroniser and one for the pending register. Mask writes, acknowledges and end-of-interrupt strobes each take effect on the single edge that registers them. Every stimulus is applied at a falling edge. Each check of `irq_out` is taken at a falling edge after the counted number of rising edges. `vec_out` is combinational, so it is sampled one time unit after `ack` is raised, still ahead of the edge that consumes it.

// File: rtl/prio_irq_pkg.sv
// Package prio_irq_pkg
// Shared helpers for the cascaded-order interrupt controller.
// Assumes the chained group is inserted directly after line casc_at of the
// primary group, and that the chained group's lines are numbered after all
// primary lines.
package prio_irq_pkg;

    // Map an urgency position (0 = most urgent) to a physical line number.
    function automatic int rank_to_line(input int pos, input int casc_at,
                                        input int n_prim, input int n_chain);
        if (pos <= casc_at)
            return pos;
        else if (pos <= casc_at + n_chain)
            return n_prim + (pos - casc_at - 1);
        else
            return pos - n_chain;
    endfunction

    // Inverse map: physical line number to urgency position.
    function automatic int line_to_rank(input int line, input int casc_at,
                                        input int n_prim, input int n_chain);
        if (line <= casc_at)
            return line;
        else if (line >= n_prim)
            return casc_at + 1 + (line - n_prim);
        else
            return line + n_chain;
    endfunction

endpackage

// File: rtl/irq_edge_sync.sv
// Module irq_edge_sync
// Brings N asynchronous request lines into the clock domain through a
// STAGES-deep flop chain and emits a one-cycle pulse per rising edge.
// Assumes each input stays at a level for at least one clock period.
module irq_edge_sync #(
    parameter int N      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] rise_o
);

    logic [N-1:0] chain_q [STAGES];
    logic [N-1:0] last_q;

    // Synchroniser chain: first stage samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain_q[0] <= '0;
        else
            chain_q[0] <= raw_i;
    end

    // Remaining synchroniser stages.
    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain_q[s] <= '0;
                else
                    chain_q[s] <= chain_q[s-1];
            end
        end
    endgenerate

    // Previous synchronised level, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= '0;
        else
            last_q <= chain_q[STAGES-1];
    end

    // Rising-edge pulse per line.
    assign rise_o = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/irq_rank_pick.sv
// Module irq_rank_pick
// Finds the most urgent set bit of a per-line vector under the cascaded
// order and reports its urgency position and its physical line number.
// Assumes N = N_PRIM + N_CHAIN and CASC_AT < N_PRIM.
module irq_rank_pick
    import prio_irq_pkg::*;
#(
    parameter int N_PRIM  = 8,
    parameter int N_CHAIN = 8,
    parameter int CASC_AT = 2,
    localparam int N      = N_PRIM + N_CHAIN,
    localparam int W      = $clog2(N)
) (
    input  logic [N-1:0] vec_i,
    output logic         any_o,
    output logic [W-1:0] rank_o,
    output logic [W-1:0] line_o
);

    logic [N-1:0] ordered;

    // Reorder the line vector so that bit 0 is the most urgent position.
    generate
        for (genvar p = 0; p < N; p++) begin : g_order
            assign ordered[p] = vec_i[rank_to_line(p, CASC_AT, N_PRIM, N_CHAIN)];
        end
    endgenerate

    // Lowest set position wins; scan from least urgent so the last hit stays.
    always_comb begin
        any_o  = 1'b0;
        rank_o = '0;
        for (int p = N - 1; p >= 0; p--) begin
            if (ordered[p]) begin
                any_o  = 1'b1;
                rank_o = W'(p);
            end
        end
    end

    // Translate the winning position back to its line number.
    always_comb begin
        line_o = W'(rank_to_line(int'(rank_o), CASC_AT, N_PRIM, N_CHAIN));
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
// Module prio_irq_ctrl
// Sixteen-line interrupt controller with cascaded fixed urgency, per-line
// mask, pending/in-service tracking, acknowledge and non-specific EOI.
// Assumes ack and eoi are single-cycle strobes from the processor side, and
// that mask, ack and eoi are synchronous to clk.
module prio_irq_ctrl #(
    parameter int N_PRIM   = 8,
    parameter int N_CHAIN  = 8,
    parameter int CASC_AT  = 2,
    parameter int SYNC_LEN = 2,
    localparam int N       = N_PRIM + N_CHAIN,
    localparam int W       = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_in,
    input  logic         mask_we,
    input  logic [N-1:0] mask_wdata,
    input  logic         ack,
    input  logic         eoi,
    output logic         irq_out,
    output logic [W-1:0] vec_out
);

    logic [N-1:0] pend_q;
    logic [N-1:0] isr_q;
    logic [N-1:0] mask_q;
    logic [N-1:0] rise;
    logic [N-1:0] eligible;
    logic [N-1:0] take_oh;
    logic [N-1:0] retire_oh;
    logic         pend_any;
    logic [W-1:0] pend_rank;
    logic [W-1:0] pend_line;
    logic         isr_any;
    logic [W-1:0] isr_rank;
    logic [W-1:0] isr_line;
    logic         take;

    // Input synchronisation and edge detection.
    irq_edge_sync #(
        .N      (N),
        .STAGES (SYNC_LEN)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (req_in),
        .rise_o (rise)
    );

    // Lines that may compete for forwarding.
    assign eligible = pend_q & ~mask_q;

    // Most urgent eligible pending line.
    irq_rank_pick #(
        .N_PRIM  (N_PRIM),
        .N_CHAIN (N_CHAIN),
        .CASC_AT (CASC_AT)
    ) u_pick_pend (
        .vec_i  (eligible),
        .any_o  (pend_any),
        .rank_o (pend_rank),
        .line_o (pend_line)
    );

    // Most urgent in-service line.
    irq_rank_pick #(
        .N_PRIM  (N_PRIM),
        .N_CHAIN (N_CHAIN),
        .CASC_AT (CASC_AT)
    ) u_pick_isr (
        .vec_i  (isr_q),
        .any_o  (isr_any),
        .rank_o (isr_rank),
        .line_o (isr_line)
    );

    // Forward only when the candidate strictly outranks all in-service lines.
    always_comb begin
        irq_out = pend_any && (!isr_any || (pend_rank < isr_rank));
        vec_out = irq_out ? pend_line : '0;
    end

    // Acknowledge and retire selections as one-hot line vectors.
    always_comb begin
        take      = ack && irq_out;
        take_oh   = take ? (N'(1) << pend_line) : '0;
        retire_oh = (eoi && isr_any) ? (N'(1) << isr_line) : '0;
    end

    // Pending bits: cleared on acknowledge, set by new edges.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else
            pend_q <= (pend_q & ~take_oh) | rise;
    end

    // In-service bits: set on acknowledge, cleared on end-of-interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)
            isr_q <= '0;
        else
            isr_q <= (isr_q & ~retire_oh) | take_oh;
    end

    // Mask register: all lines blocked out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '1;
        else if (mask_we)
            mask_q <= mask_wdata;
    end

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
// Module prio_irq_ctrl_chk
// Assertion checker for prio_irq_ctrl, attached through bind.
// Assumes it sees the controller's registered pending, in-service and mask
// state alongside its ports.
module prio_irq_ctrl_chk #(
    parameter int N = 16,
    localparam int W = $clog2(N)
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ack,
    input logic         eoi,
    input logic         irq_out,
    input logic [W-1:0] vec_out,
    input logic [N-1:0] pend,
    input logic [N-1:0] isr,
    input logic [N-1:0] mask
);

    logic seen_rst_q;

    // Remember that a reset has been applied at least once.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen_rst_q <= 1'b1;
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rst_q && $rose(rst_n)) |-> (pend == '0 && isr == '0 && mask == '1 && !irq_out));

    p_irq_has_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((pend & ~mask) != '0));

    p_vec_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_out) |-> (pend[vec_out] && !mask[vec_out]));

    p_ack_sets_isr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_out && !eoi) |=> isr[$past(vec_out)]);

    p_ack_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !irq_out && !eoi) |=> $stable(isr));

    p_eoi_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !ack && isr != '0) |=> ($countones(isr) == $countones($past(isr)) - 1));

    p_eoi_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !ack && isr == '0) |=> (isr == '0));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N(N)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ack     (ack),
    .eoi     (eoi),
    .irq_out (irq_out),
    .vec_out (vec_out),
    .pend    (pend_q),
    .isr     (isr_q),
    .mask    (mask_q)
);

// File: tb/prio_irq_ctrl_tb.sv
// Directed bench for prio_irq_ctrl: one task per scenario.
module prio_irq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req_in = '0;
    logic        mask_we = 1'b0;
    logic [15:0] mask_wdata = '0;
    logic        ack = 1'b0;
    logic        eoi = 1'b0;
    logic        irq_out;
    logic [3:0]  vec_out;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    prio_irq_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_in     (req_in),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .ack        (ack),
        .eoi        (eoi),
        .irq_out    (irq_out),
        .vec_out    (vec_out)
    );

    always #10 clk = ~clk;

    // Watchdog.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL R1: watchdog actual=%0d expected=done", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_mask(input logic [15:0] m);
        @(negedge clk);
        mask_we = 1'b1;
        mask_wdata = m;
        @(negedge clk);
        mask_we = 1'b0;
    endtask

    task automatic raise(input logic [15:0] m);
        @(negedge clk);
        req_in = req_in | m;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drop(input logic [15:0] m);
        @(negedge clk);
        req_in = req_in & ~m;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_ack(output int v, output int i);
        @(negedge clk);
        ack = 1'b1;
        #1;
        v = int'(vec_out);
        i = int'(irq_out);
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic do_eoi();
        @(negedge clk);
        eoi = 1'b1;
        @(negedge clk);
        eoi = 1'b0;
    endtask

    // Reset state, masking, first delivery.
    task automatic t_reset_mask();
        int v, i;
        apply_reset();
        chk(int'(irq_out), 0, "R1 irq low after reset");
        raise(16'h0001);
        chk(int'(irq_out), 0, "R3 masked line not forwarded");
        write_mask(16'hFFFE);
        chk(int'(irq_out), 1, "R3 unmask forwards retained pending");
        do_ack(v, i);
        chk(v, 0, "R5 vec_out line 0");
        chk(int'(irq_out), 0, "R5 irq drops after ack");
        do_eoi();
        chk(int'(irq_out), 0, "R2 held level gives no new request");
    endtask

    // Simultaneous requests delivered in cascaded order.
    task automatic t_order();
        int v, i;
        apply_reset();
        write_mask(16'h0000);
        raise(16'h010A);
        chk(int'(irq_out), 1, "R2 edge raises irq after 3 edges");
        do_ack(v, i);
        chk(v, 1, "R4 first delivery line 1");
        chk(int'(irq_out), 0, "R7 line 8 held under line 1");
        do_eoi();
        chk(int'(irq_out), 1, "R4 line 8 pending after eoi");
        do_ack(v, i);
        chk(v, 8, "R4 second delivery line 8");
        chk(int'(irq_out), 0, "R7 line 3 held under line 8");
        do_eoi();
        do_ack(v, i);
        chk(v, 3, "R4 third delivery line 3");
        do_eoi();
        chk(int'(irq_out), 0, "R4 nothing left");
    endtask

    // Nesting, blocking and end-of-interrupt choice.
    task automatic t_nest();
        int v, i;
        apply_reset();
        write_mask(16'h0000);
        raise(16'h0020);
        do_ack(v, i);
        chk(v, 5, "R5 vec_out line 5");
        raise(16'h1000);
        chk(int'(irq_out), 1, "R6 line 12 nests over line 5");
        do_ack(v, i);
        chk(v, 12, "R6 nested vec line 12");
        raise(16'h0040);
        chk(int'(irq_out), 0, "R7 line 6 held");
        do_eoi();
        raise(16'h4000);
        chk(int'(irq_out), 1, "R9 eoi retired line 12 not 5");
        do_ack(v, i);
        chk(v, 14, "R9 line 14 delivered");
        do_eoi();
        chk(int'(irq_out), 0, "R7 line 6 still held by 5");
        do_eoi();
        chk(int'(irq_out), 1, "R7 line 6 released");
        do_ack(v, i);
        chk(v, 6, "R7 line 6 delivered");
        do_eoi();
        do_eoi();
        chk(int'(irq_out), 0, "R9 eoi with nothing in service");
        raise(16'h0080);
        chk(int'(irq_out), 1, "R9 empty eoi left state usable");
    endtask

    // Merging of repeats and ignored acknowledge.
    task automatic t_merge();
        int v, i;
        apply_reset();
        write_mask(16'h0000);
        do_ack(v, i);
        chk(i, 0, "R10 ack with irq low");
        raise(16'h0080);
        chk(int'(irq_out), 1, "R10 ignored ack left no in-service line");
        do_ack(v, i);
        chk(v, 7, "R10 line 7 delivered");
        raise(16'h0001);
        do_ack(v, i);
        chk(v, 0, "R6 line 0 nests");
        raise(16'h0200);
        drop(16'h0200);
        raise(16'h0200);
        drop(16'h0200);
        raise(16'h0200);
        chk(int'(irq_out), 0, "R8 line 9 blocked");
        do_eoi();
        chk(int'(irq_out), 1, "R8 line 9 after eoi");
        do_ack(v, i);
        chk(v, 9, "R8 single delivery of line 9");
        chk(int'(irq_out), 0, "R8 no second delivery");
        do_eoi();
        do_eoi();
        chk(int'(irq_out), 0, "R8 all retired, nothing pending");
    endtask

    initial begin
        t_reset_mask();
        t_order();
        t_nest();
        t_merge();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule